// File: doc/BRIEF.md
# Multi-Ratio DDR Input Deserializer

This block turns one double-data-rate serial line into parallel words delivered on a slower system clock. Every edge of a fast capture clock takes one sample. Rising and falling samples are kept in two short history registers. On each system-clock rising edge, the newest group of bits is read out of those histories and registered as one word. A two-bit gear code picks the ratio: 2, 4 or 7 bits per word. The 4:1 gear suits line rates above 400 Mbps, where a 2:1 design would need a system clock above 200 MHz. The 7:1 gear is the one video links use.

The system clock must be a divided copy of the fast clock. Each system period spans exactly as many fast half-cycles as the word has bits. Each system rising edge trails a fast-clock edge within the same half period. In 2:1 use, the system clock itself is wired to the fast-clock input. In 7:1 use, the system clock alternates high phases of 3 half-cycles with low phases of 4 half-cycles. Its rising edges therefore fall alternately after rising and after falling fast edges, and the block tracks which kind of edge came last. A one-cycle bitslip pulse moves the word boundary one bit earlier in the stream. Pad buffers, delay lines, clock generation and alignment training belong to the surrounding logic.

Top module: `ddr_deser`

## Requirements
- R1: The serial stream is ordered by capture time, with each rising-edge sample coming before the falling-edge sample that follows it. Within a word, the earliest captured bit lands on bit 0.
- R2: While `rst_i` is high at a system-clock rising edge, that edge drives `word_o` to zero and `valid_o` low.
- R3: After reset release, `valid_o` stays low at the first system-clock rising edge and goes high at the second. It then stays high until the next reset.
- R4: Gear code 2'b00 gives 2-bit words with the system clock at the fast-clock rate. Each word holds the two samples taken since the previous system edge.
- R5: Gear code 2'b01 gives 4-bit words with the system clock at half the fast-clock rate. Each word holds the four samples taken since the previous system edge.
- R6: Gear codes 2'b10 and 2'b11 both give 7-bit words, with a system period of 3.5 fast cycles. Consecutive words cover consecutive 7-bit groups of the stream with no gap and no overlap.
- R7: Word bits at positions equal to or above the selected ratio read zero.
- R8: When `bitslip_i` is high at a system edge, the word registered at that edge is unchanged. Each later word is taken one bit earlier in the stream per pulse received. After ratio-minus-one pulses, the next pulse returns the offset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk_i | input | 1 | Fast capture clock; both edges sample `din_i` |
| sclk_i | input | 1 | System clock on which words are delivered |
| rst_i | input | 1 | Active-high synchronous reset, seen by both clocks |
| mode_i | input | 2 | Static gear code: 00 = 2:1, 01 = 4:1, 10 or 11 = 7:1 |
| din_i | input | 1 | Serial DDR data |
| bitslip_i | input | 1 | One-cycle pulse on `sclk_i` that moves the word boundary by one bit |
| word_o | output | WORD_W | Parallel word, earliest bit at bit 0 |
| valid_o | output | 1 | High once a full word has been assembled after reset |

## Verification
An alternating one/zero stream checks bit order: any swap of the rising and falling samples, or of the word's bit order, reverses the words. A pseudo-random stream is run in each gear. It separates contiguous grouping from dropped or repeated bits, and it shows whether the 7:1 path picks the right edge kind on alternating system edges. A stream of slow runs, with bitslip pulses spaced through it, drives the offset through its wrap in 7:1 and in the narrower gears. The unused 2'b11 code is also run and must behave like 7:1.

// File: rtl/ddr_deser_pkg.sv
`timescale 1ns/1ps
package ddr_deser_pkg;

   typedef enum logic [1:0] {
      GEAR_X2  = 2'b00,
      GEAR_X4  = 2'b01,
      GEAR_X7  = 2'b10,
      GEAR_X7B = 2'b11
   } gear_e;

   // bits per word for a gear code
   function automatic int unsigned gear_bits(input logic [1:0] code);
      case (gear_e'(code))
         GEAR_X2: return 2;
         GEAR_X4: return 4;
         default: return 7;
      endcase
   endfunction

endpackage

// File: rtl/ddr_edge_capture.sv
`timescale 1ns/1ps
module ddr_edge_capture #(
   parameter int DEPTH = 7
) (
   input  logic             fclk_i,
   input  logic             rst_i,
   input  logic             din_i,
   output logic [DEPTH-1:0] rise_hist_o,
   output logic [DEPTH-1:0] fall_hist_o,
   output logic             last_rise_o
);

   logic rise_tog_q;
   logic fall_tog_q;

   // rising-edge samples, newest at index 0
   always_ff @(posedge fclk_i) begin
      if (rst_i) begin
         rise_hist_o <= '0;
         rise_tog_q  <= 1'b0;
      end else begin
         rise_hist_o <= {rise_hist_o[DEPTH-2:0], din_i};
         rise_tog_q  <= ~rise_tog_q;
      end
   end

   // falling-edge samples; the toggle copy marks that a fall came last
   always_ff @(negedge fclk_i) begin
      if (rst_i) begin
         fall_hist_o <= '0;
         fall_tog_q  <= 1'b0;
      end else begin
         fall_hist_o <= {fall_hist_o[DEPTH-2:0], din_i};
         fall_tog_q  <= rise_tog_q;
      end
   end

   assign last_rise_o = rise_tog_q ^ fall_tog_q;

endmodule

// File: rtl/ddr_word_select.sv
`timescale 1ns/1ps
module ddr_word_select #(
   parameter int DEPTH  = 7,
   parameter int WORD_W = 7,
   parameter int OFS_W  = 3,
   parameter int NB_W   = 3
) (
   input  logic [DEPTH-1:0]  rise_hist_i,
   input  logic [DEPTH-1:0]  fall_hist_i,
   input  logic              last_rise_i,
   input  logic [NB_W-1:0]   nbits_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [WORD_W-1:0] word_o
);

   localparam int MERGE_W = 2 * DEPTH;
   localparam int IDX_W   = $clog2(MERGE_W);

   // merged stream, index 0 = most recent sample
   logic [MERGE_W-1:0] merged;

   for (genvar k = 0; k < DEPTH; k++) begin : g_merge
      assign merged[2*k]   = last_rise_i ? rise_hist_i[k] : fall_hist_i[k];
      assign merged[2*k+1] = last_rise_i ? fall_hist_i[k] : rise_hist_i[k];
   end

   for (genvar gi = 0; gi < WORD_W; gi++) begin : g_bit
      logic [IDX_W-1:0] idx;
      assign idx = IDX_W'(ofs_i) + IDX_W'(nbits_i) - IDX_W'(gi + 1);
      assign word_o[gi] = (NB_W'(gi) < nbits_i) ? merged[idx] : 1'b0;
   end

endmodule

// File: rtl/ddr_word_stage.sv
`timescale 1ns/1ps
module ddr_word_stage #(
   parameter int WORD_W = 7,
   parameter int OFS_W  = 3,
   parameter int NB_W   = 3
) (
   input  logic              sclk_i,
   input  logic              rst_i,
   input  logic              bitslip_i,
   input  logic [NB_W-1:0]   nbits_i,
   input  logic [WORD_W-1:0] word_raw_i,
   output logic [OFS_W-1:0]  ofs_o,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);

   logic started_q;

   always_ff @(posedge sclk_i) begin
      if (rst_i) begin
         word_o    <= '0;
         valid_o   <= 1'b0;
         started_q <= 1'b0;
         ofs_o     <= '0;
      end else begin
         word_o    <= word_raw_i;
         started_q <= 1'b1;
         valid_o   <= started_q;
         if (bitslip_i) begin
            if (NB_W'(ofs_o) + NB_W'(1) >= nbits_i) ofs_o <= '0;
            else                                    ofs_o <= ofs_o + OFS_W'(1);
         end
      end
   end

endmodule

// File: rtl/ddr_deser.sv
`timescale 1ns/1ps
module ddr_deser #(
   parameter int WORD_W = 7
) (
   input  logic              fclk_i,
   input  logic              sclk_i,
   input  logic              rst_i,
   input  logic [1:0]        mode_i,
   input  logic              din_i,
   input  logic              bitslip_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);

   localparam int DEPTH = WORD_W;
   localparam int OFS_W = $clog2(WORD_W);
   localparam int NB_W  = $clog2(WORD_W + 1);

   if (WORD_W < 7 || WORD_W > 15) begin : g_bad_width
      $error("ddr_deser: WORD_W must lie in 7..15");
   end

   logic [DEPTH-1:0]  rise_hist;
   logic [DEPTH-1:0]  fall_hist;
   logic              last_rise;
   logic [NB_W-1:0]   nbits;
   logic [OFS_W-1:0]  slip_ofs;
   logic [WORD_W-1:0] word_raw;

   assign nbits = NB_W'(ddr_deser_pkg::gear_bits(mode_i));

   ddr_edge_capture #(.DEPTH(DEPTH)) u_cap (
      .fclk_i      (fclk_i),
      .rst_i       (rst_i),
      .din_i       (din_i),
      .rise_hist_o (rise_hist),
      .fall_hist_o (fall_hist),
      .last_rise_o (last_rise)
   );

   ddr_word_select #(
      .DEPTH(DEPTH), .WORD_W(WORD_W), .OFS_W(OFS_W), .NB_W(NB_W)
   ) u_sel (
      .rise_hist_i (rise_hist),
      .fall_hist_i (fall_hist),
      .last_rise_i (last_rise),
      .nbits_i     (nbits),
      .ofs_i       (slip_ofs),
      .word_o      (word_raw)
   );

   ddr_word_stage #(
      .WORD_W(WORD_W), .OFS_W(OFS_W), .NB_W(NB_W)
   ) u_stage (
      .sclk_i     (sclk_i),
      .rst_i      (rst_i),
      .bitslip_i  (bitslip_i),
      .nbits_i    (nbits),
      .word_raw_i (word_raw),
      .ofs_o      (slip_ofs),
      .word_o     (word_o),
      .valid_o    (valid_o)
   );

endmodule

// File: rtl/ddr_deser_chk.sv
`timescale 1ns/1ps
module ddr_deser_chk #(
   parameter int WORD_W = 7,
   parameter int OFS_W  = $clog2(WORD_W)
) (
   input logic              sclk_i,
   input logic              rst_i,
   input logic [1:0]        mode_i,
   input logic              bitslip_i,
   input logic [WORD_W-1:0] word_o,
   input logic              valid_o,
   input logic [OFS_W-1:0]  slip_ofs
);

   function automatic logic [WORD_W-1:0] used_mask(input logic [1:0] code);
      return WORD_W'((1 << ddr_deser_pkg::gear_bits(code)) - 1);
   endfunction

   p_reset_clears_r2: assert property (@(posedge sclk_i)
      rst_i |=> (!valid_o && word_o == '0));

   p_valid_sticky_r3: assert property (@(posedge sclk_i) disable iff (rst_i)
      valid_o |=> valid_o);

   p_upper_zero_r7: assert property (@(posedge sclk_i) disable iff (rst_i)
      valid_o |-> ((word_o & ~used_mask(mode_i)) == '0));

   p_slip_moves_r8: assert property (@(posedge sclk_i) disable iff (rst_i)
      bitslip_i |=> (slip_ofs != $past(slip_ofs)));

   p_slip_holds_r8: assert property (@(posedge sclk_i) disable iff (rst_i)
      !bitslip_i |=> $stable(slip_ofs));

   p_slip_range_r8: assert property (@(posedge sclk_i) disable iff (rst_i)
      int'(slip_ofs) < int'(ddr_deser_pkg::gear_bits(mode_i)));

endmodule

bind ddr_deser ddr_deser_chk #(.WORD_W(WORD_W)) u_chk (
   .sclk_i    (sclk_i),
   .rst_i     (rst_i),
   .mode_i    (mode_i),
   .bitslip_i (bitslip_i),
   .word_o    (word_o),
   .valid_o   (valid_o),
   .slip_ofs  (slip_ofs)
);

// File: tb/ddr_deser_bench.sv
`timescale 1ns/1ps
module ddr_deser_bench;

   logic       fclk = 1'b0;
   logic       sclk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       din = 1'b0;
   logic       bitslip = 1'b0;
   logic [6:0] word;
   logic       valid;

   int  gear = 2;
   int  pat = 0;
   int  hcnt = 0;
   bit  resync = 1'b1;
   int  total = 0;
   int  bad = 0;
   int  slips = 0;
   bit  done = 1'b0;
   bit  bits[$];

   ddr_deser #(.WORD_W(7)) u_ddr_deser (
      .fclk_i(fclk), .sclk_i(sclk), .rst_i(rst), .mode_i(mode),
      .din_i(din), .bitslip_i(bitslip), .word_o(word), .valid_o(valid)
   );

   always #5 fclk = ~fclk;   // 100 MHz

   // stream record and divided system clock, trailing each fast edge by 1 ns
   always @(posedge fclk or negedge fclk) begin
      if (rst) bits.delete();
      else begin
         bits.push_back(din);
         if (bits.size() > 40) void'(bits.pop_front());
      end
      if (resync && fclk) begin
         hcnt = 0;
         resync = 1'b0;
      end
      if (!resync) begin
         if (hcnt == 0) sclk <= #1 1'b1;
         if (hcnt == gear / 2) sclk <= #1 1'b0;
         hcnt = (hcnt + 1) % gear;
      end else begin
         sclk <= #1 1'b0;
      end
   end

   // serial data, changed mid half-period
   initial begin
      logic [15:0] lf;
      int run;
      lf = 16'hACE1;
      run = 0;
      forever begin
         @(posedge fclk or negedge fclk);
         #2.5;
         if (rst) din = 1'b0;
         else begin
            case (pat)
               1: din = ~fclk;
               2: begin
                  lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                  din = lf[0];
               end
               3: begin
                  run++;
                  din = ((run / 3) % 2) == 1;
               end
               default: din = 1'b0;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, compared on every system edge
   bit started = 1'b0;
   int ofs = 0;
   always @(posedge sclk) begin
      logic [6:0] e_word;
      logic       e_valid;
      bit         in_rst;
      string      tag;
      int         len;
      in_rst = rst;
      e_word = '0;
      if (in_rst) begin
         e_valid = 1'b0;
         started = 1'b0;
         ofs = 0;
      end else begin
         len = bits.size();
         for (int i = 0; i < gear; i++) begin
            int j;
            j = len - 1 - (ofs + gear - 1 - i);
            if (j >= 0) e_word[i] = bits[j];
         end
         e_valid = started;
         started = 1'b1;
         if (bitslip) begin
            ofs = (ofs + 1) % gear;
            slips++;
         end
      end
      #0.5;
      if (in_rst) begin
         chk("R2 valid in reset", {6'b0, valid}, 7'd0);
         chk("R2 word in reset", word, 7'd0);
      end else begin
         chk("R3 valid timing", {6'b0, valid}, {6'b0, e_valid});
         if (e_valid) begin
            if (pat == 1)        tag = "R1 bit order";
            else if (slips > 0)  tag = "R8 slipped word";
            else if (gear == 2)  tag = "R4 2:1 word";
            else if (gear == 4)  tag = "R5 4:1 word";
            else                 tag = "R6 7:1 word";
            chk(tag, word, e_word);
            chk("R7 upper bits", word >> gear, 7'd0);
         end
      end
   end

   task automatic phase(input logic [1:0] m, input int g, input int p,
                        input int ncyc, input int slip_every);
      @(posedge sclk); #3;
      rst = 1'b1;
      repeat (3) @(posedge sclk);
      #3;
      mode = m;
      gear = g;
      resync = 1'b1;
      repeat (4) @(posedge sclk);
      #3;
      pat = p;
      slips = 0;
      rst = 1'b0;
      for (int c = 0; c < ncyc; c++) begin
         @(posedge sclk); #3;
         bitslip = (slip_every > 0) && (c % slip_every == slip_every - 1);
      end
      @(posedge sclk); #3;
      bitslip = 1'b0;
   endtask

   initial begin
      repeat (6) @(posedge sclk);
      phase(2'b00, 2, 1, 30, 0);    // R1, R4
      phase(2'b00, 2, 2, 40, 10);   // R4, R8
      phase(2'b01, 4, 2, 60, 9);    // R5, R8
      phase(2'b10, 7, 2, 80, 0);    // R6
      phase(2'b10, 7, 3, 100, 7);   // R8 wrap in 7:1
      phase(2'b11, 7, 2, 40, 0);    // R6 spare code
      phase(2'b01, 4, 1, 20, 0);    // R1 in 4:1
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R3 watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule